// File: doc/BRIEF.md
# Cascadable Up/Down Wrap Counter with Stretched Terminal Pulse

This block is a 16-bit binary counter that moves one step up or down whenever a step request arrives. The step request comes from one of two places. It can be a one-cycle enable tick from a shared clock divider. It can also be the high-to-low transition of an external cascade input, which is first brought into the local clock domain by a synchronizer. A load strobe writes a new value directly into the count.

When the count wraps, the block starts a terminal-count pulse that lasts a fixed number of clock periods. Counting up wraps from all ones to zero; counting down wraps from zero to all ones. A per-counter output enable gates the pulse at the output.

To build a wider counter, connect the gated terminal count of one instance to the cascade input of the next instance. Set the select on that next instance to the cascade source. The upper instance then advances once for every completed wrap of the lower one.

Top module: `cascade_wrap_counter`

## Requirements
- R1: While rst_n is low, count_o is 0x0000 and tc_o is 0, and the synchronizer state is cleared to zero.
- R2: With src_sel_i=0, each rising edge where tick_i=1 changes count_o by +1 if dir_up_i=1, or by -1 if dir_up_i=0. When tick_i=0, the count holds.
- R3: A step up taken while the count is 0xFFFF makes the count 0x0000 and starts a terminal-count pulse.
- R4: A step down taken while the count is 0x0000 makes the count 0xFFFF and starts a terminal-count pulse.
- R5: The internal terminal count is high for exactly 4 clock periods, starting right after the wrapping edge. A new wrap while the pulse is high restarts the 4-period window.
- R6: A rising edge with load_i=1 sets the count to load_val_i. This takes priority over any step in that cycle, and a load never starts a terminal-count pulse.
- R7: tc_o is the internal terminal count ANDed with tc_oe_i. The pulse timing runs on even while tc_oe_i=0.
- R8: With src_sel_i=1, tick_i is ignored and the counter steps once per high-to-low transition of cascade_i. The step happens at the third rising edge, counting from the first edge that samples cascade_i low. Rising transitions do not step the counter.
- R9: When one instance's tc_o drives a second instance's cascade_i (second instance with src_sel_i=1), the second instance advances exactly once per wrap of the first, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Step enable from the shared divider |
| cascade_i | input | 1 | Terminal count of the preceding stage |
| src_sel_i | input | 1 | 0: step on tick_i, 1: step on falling edge of cascade_i |
| dir_up_i | input | 1 | 1 counts up, 0 counts down |
| load_i | input | 1 | Load strobe |
| load_val_i | input | 16 | Value written by the load strobe |
| tc_oe_i | input | 1 | Output enable for the terminal count |
| count_o | output | 16 | Current count |
| tc_o | output | 1 | Gated stretched terminal count |

## Verification
Two events can land on the same edge. A load can coincide with a step that would wrap, and a second wrap can arrive while an earlier pulse is still stretching. The bench provokes the first case by asserting load_i with tick_i while the count sits at 0xFFFF. It provokes the second by reloading the boundary value and stepping again two cycles after a wrap. A behavioural model of both chained instances is compared on every falling clock edge. The model judges the first case by the absence of any pulse, and the second by the pulse lasting four periods from the later wrap.

// File: rtl/cascade_wrap_counter.sv
module cascade_wrap_counter #(
  parameter int WIDTH       = 16,
  parameter int STRETCH     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cascade_i,
  input  logic             src_sel_i,
  input  logic             dir_up_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             tc_oe_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  localparam int SW = $clog2(STRETCH + 1);
  localparam logic [WIDTH-1:0] MAXV = '1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   casc_prev;
  logic [WIDTH-1:0]       cnt;
  logic [SW-1:0]          hold;
  logic                   casc_fall, step, at_edge, wrap, tc_raw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q    <= '0;
      casc_prev <= 1'b0;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], cascade_i};
      casc_prev <= sync_q[SYNC_STAGES-1];
    end

  assign casc_fall = casc_prev & ~sync_q[SYNC_STAGES-1];
  assign step      = src_sel_i ? casc_fall : tick_i;
  assign at_edge   = dir_up_i ? (cnt == MAXV) : (cnt == '0);
  assign wrap      = step & ~load_i & at_edge;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '0;
    else if (load_i)     cnt <= load_val_i;
    else if (step)       cnt <= dir_up_i ? cnt + 1'b1 : cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          hold <= '0;
    else if (wrap)       hold <= SW'(STRETCH);
    else if (hold != '0) hold <= hold - 1'b1;

  assign tc_raw  = (hold != '0);
  assign count_o = cnt;
  assign tc_o    = tc_raw & tc_oe_i;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_i) |=> $stable(cnt));
  p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && dir_up_i && !load_i && cnt == MAXV) |=> (cnt == '0 && tc_raw));
  p_down_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !dir_up_i && !load_i && cnt == '0) |=> (cnt == MAXV && tc_raw));
  p_tc_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_raw) |=> tc_raw);
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt == $past(load_val_i)));
  p_load_no_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !tc_raw) |=> !tc_raw);
  p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    casc_fall |=> !casc_fall);
endmodule

// File: tb/tb_cascade_wrap_counter.sv
module tb_cascade_wrap_counter;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic lo_tick = 0, lo_dir = 1, lo_load = 0, lo_oe = 1;
  logic hi_tick = 0, hi_dir = 1, hi_load = 0;
  logic [15:0] lo_val = '0, hi_val = '0;
  logic [15:0] lo_cnt, hi_cnt;
  logic lo_tc, hi_tc;

  cascade_wrap_counter dut (
    .clk(clk), .rst_n(rst_n), .tick_i(lo_tick), .cascade_i(1'b0), .src_sel_i(1'b0),
    .dir_up_i(lo_dir), .load_i(lo_load), .load_val_i(lo_val), .tc_oe_i(lo_oe),
    .count_o(lo_cnt), .tc_o(lo_tc));

  cascade_wrap_counter u_hi (
    .clk(clk), .rst_n(rst_n), .tick_i(hi_tick), .cascade_i(lo_tc), .src_sel_i(1'b1),
    .dir_up_i(hi_dir), .load_i(hi_load), .load_val_i(hi_val), .tc_oe_i(1'b1),
    .count_o(hi_cnt), .tc_o(hi_tc));

  int n_cmp = 0, n_bad = 0;
  string phase = "R1 reset";
  int m_cnt0 = 0, m_st0 = 0, m_cnt1 = 0, m_st1 = 0, m_wraps0 = 0;
  bit h1 = 0, h2 = 0, h3 = 0, c_now, fall, w0, w1;

  task automatic model_step(inout int cnt, inout int st, input bit stp, input bit up,
                            input bit ld, input logic [15:0] v, output bit w);
    w = 0;
    if (ld) cnt = v;
    else if (stp) begin
      if (up) begin
        if (cnt == 65535) begin cnt = 0; w = 1; end else cnt = cnt + 1;
      end else begin
        if (cnt == 0) begin cnt = 65535; w = 1; end else cnt = cnt - 1;
      end
    end
    if (w) st = 4;
    else if (st > 0) st = st - 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt0 = 0; m_st0 = 0; m_cnt1 = 0; m_st1 = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      c_now = (m_st0 > 0) && lo_oe;
      fall  = h3 && !h2;
      model_step(m_cnt0, m_st0, lo_tick, lo_dir, lo_load, lo_val, w0);
      if (w0) m_wraps0++;
      model_step(m_cnt1, m_st1, fall, hi_dir, hi_load, hi_val, w1);
      h3 = h2; h2 = h1; h1 = c_now;
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(lo_cnt == m_cnt0[15:0], "lower count", lo_cnt, m_cnt0);
    chk(lo_tc == ((m_st0 > 0) && lo_oe), "lower tc", lo_tc, (m_st0 > 0) && lo_oe);
    chk(hi_cnt == m_cnt1[15:0], "upper count", hi_cnt, m_cnt1);
    chk(hi_tc == (m_st1 > 0), "upper tc", hi_tc, m_st1 > 0);
  end

  task automatic nxt(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic load_lo(logic [15:0] v, bit t);
    lo_load = 1; lo_val = v; lo_tick = t; nxt(); lo_load = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  int start;
  initial begin
    nxt(3);
    chk(lo_cnt == 0 && hi_cnt == 0 && !lo_tc && !hi_tc, "R1 reset values", lo_cnt, 0);
    rst_n = 1;
    phase = "R2 up/down stepping";
    for (int i = 0; i < 20; i++) begin lo_tick = (i % 3 != 0); hi_tick = i[0]; nxt(); end
    lo_dir = 0;
    for (int i = 0; i < 30; i++) begin lo_tick = (i % 4 != 1); hi_tick = ~i[1]; nxt(); end
    lo_tick = 0; nxt(6);
    phase = "R3 overflow";
    lo_dir = 1; load_lo(16'hFFFE, 1);
    lo_tick = 1; nxt(3); lo_tick = 0; nxt(6);
    phase = "R6 load beats wrap";
    load_lo(16'hFFFF, 1); load_lo(16'hFFFF, 1); lo_tick = 0; nxt(6);
    chk(!lo_tc && lo_cnt == 16'hFFFF, "R6 no pulse on load", lo_tc, 0);
    phase = "R4 underflow";
    lo_dir = 0; load_lo(16'h0001, 0);
    lo_tick = 1; nxt(3); lo_tick = 0; nxt(6);
    phase = "R5 pulse restart";
    lo_dir = 1; load_lo(16'hFFFF, 0);
    lo_tick = 1; nxt(); lo_tick = 0; nxt(2);
    load_lo(16'hFFFF, 0); lo_tick = 1; nxt(); lo_tick = 0; nxt(8);
    phase = "R7 output enable";
    lo_oe = 0; load_lo(16'hFFFF, 0);
    lo_tick = 1; nxt(); lo_tick = 0; nxt(2); lo_oe = 1; nxt(8);
    phase = "R9 R8 chain up";
    hi_dir = 1; start = hi_cnt; m_wraps0 = 0;
    for (int r = 0; r < 5; r++) begin
      load_lo(16'hFFFA, 0);
      lo_tick = 1; for (int i = 0; i < 10; i++) begin hi_tick = i[0]; nxt(); end
      lo_tick = 0; for (int i = 0; i < 10; i++) begin hi_tick = ~i[0]; nxt(); end
    end
    chk(16'(hi_cnt - start[15:0]) == 16'(m_wraps0) && m_wraps0 == 5,
        "R9 upper steps per lower wrap (up)", hi_cnt - start, 5);
    phase = "R9 R8 chain down";
    hi_dir = 0; lo_dir = 0; start = hi_cnt; m_wraps0 = 0;
    for (int r = 0; r < 5; r++) begin
      load_lo(16'h0005, 0);
      lo_tick = 1; for (int i = 0; i < 10; i++) begin hi_tick = ~i[0]; nxt(); end
      lo_tick = 0; for (int i = 0; i < 10; i++) begin hi_tick = i[0]; nxt(); end
    end
    chk(16'(start[15:0] - hi_cnt) == 16'(m_wraps0) && m_wraps0 == 5,
        "R9 upper steps per lower wrap (down)", start - hi_cnt, 5);
    nxt(4);
    finish_run();
  end
endmodule